// File: doc/BRIEF.md
# Tag-Checking Load Filter

This block sits between an accelerator's read port and the memory side of its DMA path. The input region in memory holds a tag word after every run of `STRIDE` data words. The first tag sits at a configurable physical position, counted in words from the region base, and this position changes from run to run. The accelerator keeps working in logical word indices and never sees a tag word. For each logical request the filter works out the physical start address and the physical burst length so that the burst also covers the tag words around the requested data. It then reads the returned beats, checks each tag word against the expected source tag, and passes only the data words on to the accelerator.

If a tag word does not match, the filter forwards nothing more and raises `abort`. It accepts the rest of the burst from memory and drops it, so the memory side stays consistent. After that it refuses every new request until reset. Requests are served one at a time and in order. The physical position of each data word is computed with a small serial divider, and the tag phase is then tracked with a single countdown.

Top module: `tag_load_filter`

## Requirements
- R1: After reset `acc_req_ready` is 1, and `mem_req_valid`, `acc_rd_valid` and `abort` are 0.
- R2: Tags occupy physical positions `first + k*(stride+1)` for k ≥ 0, where `first` and `stride` (≥1) are sampled when a request is accepted. Logical word i maps to the i-th non-tag position. `mem_req_addr` equals `cfg_base` plus the physical position of the first requested word, minus one when that position is directly preceded by a tag.
- R3: `mem_req_len` spans from that start to the physical position of the last requested word, plus one when the next position is a tag. For example, stride 1, first 1, index 0 and length 2 give a 4-word burst.
- R4: Only data words reach `acc_rd_data`, in logical order. Each word is the memory word at the physical position of its logical index, and no tag word is ever forwarded.
- R5: A tag beat whose value differs from the sampled `cfg_src_tag` raises `abort` on the next cycle. No data beat is forwarded from that beat onwards.
- R6: After a mismatch, `mem_rd_ready` stays 1 until every remaining beat of the burst has been accepted.
- R7: Once `abort` is 1 it stays 1 until reset, and while it is 1 `acc_req_ready` and `mem_req_valid` stay 0.
- R8: Only one request is in flight. `acc_req_ready` is 0 from acceptance until the last beat of the burst. `mem_req_valid`, `mem_req_addr` and `mem_req_len` hold steady until `mem_req_ready` is seen.
- R9: A request of length 0 is consumed without a memory request, and the filter is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | AW | Physical base address of the input region |
| cfg_stride | input | SW | Data words between consecutive tags (≥1) |
| cfg_first | input | IW | Physical position of the first tag from the base |
| cfg_src_tag | input | DW | Value every tag word must hold |
| acc_req_valid | input | 1 | Accelerator read request valid |
| acc_req_ready | output | 1 | Filter can take a request |
| acc_req_idx | input | IW | Logical index of the first word |
| acc_req_len | input | LW | Number of logical words |
| mem_req_valid | output | 1 | Physical read request valid |
| mem_req_ready | input | 1 | Memory side takes the request |
| mem_req_addr | output | AW | Physical start address |
| mem_req_len | output | LW+1 | Physical burst length in words |
| mem_rd_valid | input | 1 | Read beat valid |
| mem_rd_ready | output | 1 | Filter takes the read beat |
| mem_rd_data | input | DW | Read beat data |
| acc_rd_valid | output | 1 | Data word for the accelerator valid |
| acc_rd_ready | input | 1 | Accelerator takes the word |
| acc_rd_data | output | DW | Data word for the accelerator |
| abort | output | 1 | Tag violation seen; run stopped |

## Verification
The bench targets four cases at the edges of the tag map:
- **A burst that starts before the first tag.** A design that applies the tag count for positions after the first tag would shift the start address.
- **A first word directly after a tag, or a last word directly before one.** Getting the leading or trailing inclusion wrong gives an off-by-one length.
- **A stride of one.** Here every other beat is a tag, so an error in the countdown reload would forward tags or drop data.
- **A corrupted tag in the middle of a burst.** This checks that the words before it arrive, nothing after it leaks, the rest of the burst is still drained, and a later request is refused.

// File: rtl/tag_load_filter.sv
module tag_load_filter #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 16,
  parameter int LW = 12,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [SW-1:0] cfg_stride,
  input  logic [IW-1:0] cfg_first,
  input  logic [DW-1:0] cfg_src_tag,
  input  logic          acc_req_valid,
  output logic          acc_req_ready,
  input  logic [IW-1:0] acc_req_idx,
  input  logic [LW-1:0] acc_req_len,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic [LW:0]   mem_req_len,
  input  logic          mem_rd_valid,
  output logic          mem_rd_ready,
  input  logic [DW-1:0] mem_rd_data,
  output logic          acc_rd_valid,
  input  logic          acc_rd_ready,
  output logic [DW-1:0] acc_rd_data,
  output logic          abort
);
  localparam int PLW = LW + 1;
  localparam int GW  = (IW > SW) ? IW : SW;
  localparam int CW  = $clog2(IW) + 1;

  typedef enum logic [2:0] {S_IDLE, S_DIV, S_ISSUE, S_STREAM, S_HALT} st_t;
  st_t st;

  logic [AW-1:0]  base_q;
  logic [SW-1:0]  s_q;
  logic [IW-1:0]  first_q, i0_q, i1_q;
  logic [DW-1:0]  tag_q;
  logic           phase_q;
  logic [CW-1:0]  dcnt;
  logic [IW-1:0]  dv_q, q0, q1;
  logic [SW-1:0]  dv_r, r0, r1;
  logic [PLW-1:0] left_q;
  logic [GW-1:0]  gap_q;
  logic           abort_q;

  // one restoring division step
  logic [SW:0]   dstep;
  logic          dge;
  logic [SW-1:0] r_nx;
  logic [IW-1:0] q_nx;
  assign dstep = {dv_r, dv_q[IW-1]};
  assign dge   = dstep >= {1'b0, s_q};
  assign r_nx  = dge ? SW'(dstep - {1'b0, s_q}) : dstep[SW-1:0];
  assign q_nx  = {dv_q[IW-2:0], dge};

  // physical window of the current request
  logic          lo0, lo1, lead, trail;
  logic [IW-1:0] j0, j1;
  logic [AW-1:0] p0, p1, ps, pe;
  logic [GW-1:0] gap0;
  assign lo0   = i0_q < first_q;
  assign lo1   = i1_q < first_q;
  assign j0    = i0_q - first_q;
  assign j1    = i1_q - first_q;
  assign p0    = lo0 ? AW'(i0_q) : AW'(first_q) + AW'(1) + AW'(j0) + AW'(q0);
  assign p1    = lo1 ? AW'(i1_q) : AW'(first_q) + AW'(1) + AW'(j1) + AW'(q1);
  assign lead  = !lo0 && (r0 == '0);
  assign trail = lo1 ? (i1_q == first_q - IW'(1)) : (r1 == s_q - SW'(1));
  assign ps    = p0 - AW'(lead);
  assign pe    = p1 + AW'(trail);
  assign gap0  = lead ? '0 : (lo0 ? GW'(first_q - i0_q) : GW'(s_q - r0));

  assign mem_req_valid = (st == S_ISSUE);
  assign mem_req_addr  = base_q + ps;
  assign mem_req_len   = PLW'(pe - ps + AW'(1));
  assign acc_req_ready = (st == S_IDLE);

  // in-line tag stripping and checking
  logic is_tag, bad, beat;
  assign is_tag       = (gap_q == '0);
  assign acc_rd_valid = (st == S_STREAM) && mem_rd_valid && !is_tag && !abort_q;
  assign acc_rd_data  = mem_rd_data;
  assign mem_rd_ready = (st == S_STREAM) && (is_tag || abort_q || acc_rd_ready);
  assign bad          = (st == S_STREAM) && mem_rd_valid && is_tag && !abort_q &&
                        (mem_rd_data != tag_q);
  assign beat         = mem_rd_valid && mem_rd_ready;
  assign abort        = abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      s_q     <= SW'(1);
      first_q <= '0;
      tag_q   <= '0;
      i0_q    <= '0;
      i1_q    <= '0;
      phase_q <= 1'b0;
      dcnt    <= '0;
      dv_q    <= '0;
      dv_r    <= '0;
      q0      <= '0;
      q1      <= '0;
      r0      <= '0;
      r1      <= '0;
      left_q  <= '0;
      gap_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (acc_req_valid) begin
          base_q  <= cfg_base;
          s_q     <= cfg_stride;
          first_q <= cfg_first;
          tag_q   <= cfg_src_tag;
          i0_q    <= acc_req_idx;
          i1_q    <= acc_req_idx + IW'(acc_req_len) - IW'(1);
          dv_q    <= (acc_req_idx >= cfg_first) ? acc_req_idx - cfg_first : '0;
          dv_r    <= '0;
          dcnt    <= '0;
          phase_q <= 1'b0;
          if (acc_req_len != '0) st <= S_DIV;
        end
        S_DIV: begin
          dv_q <= q_nx;
          dv_r <= r_nx;
          dcnt <= dcnt + CW'(1);
          if (dcnt == CW'(IW - 1)) begin
            dcnt <= '0;
            dv_r <= '0;
            if (!phase_q) begin
              q0      <= q_nx;
              r0      <= r_nx;
              phase_q <= 1'b1;
              dv_q    <= lo1 ? '0 : j1;
            end else begin
              q1 <= q_nx;
              r1 <= r_nx;
              st <= S_ISSUE;
            end
          end
        end
        S_ISSUE: if (mem_req_ready) begin
          left_q <= mem_req_len;
          gap_q  <= gap0;
          st     <= S_STREAM;
        end
        S_STREAM: begin
          if (bad) abort_q <= 1'b1;
          if (beat) begin
            gap_q  <= is_tag ? GW'(s_q) : gap_q - GW'(1);
            left_q <= left_q - PLW'(1);
            if (left_q == PLW'(1)) st <= (abort_q || bad) ? S_HALT : S_IDLE;
          end
        end
        default: st <= S_HALT;
      endcase
    end
  end

  p_abort_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> abort);
  p_halt_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!acc_req_ready && !mem_req_valid));
  p_bad_tag_aborts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> abort);
  p_no_fwd_after_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !acc_rd_valid);
  p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && left_q != '0 && mem_rd_valid && st == S_STREAM) |-> mem_rd_ready);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len)));
  p_one_at_a_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || mem_rd_ready) |-> !acc_req_ready);
  p_len_covers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (AW'(mem_req_len) > AW'(i1_q - i0_q)));
endmodule

// File: tb/tb_tag_load_filter.sv
module tb_tag_load_filter;
  localparam int AW = 32, DW = 32, IW = 16, LW = 12, SW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_stride = 8'd1;
  logic [IW-1:0] cfg_first = '0;
  logic [DW-1:0] cfg_src_tag = '0;
  logic acc_req_valid = 1'b0, acc_req_ready;
  logic [IW-1:0] acc_req_idx = '0;
  logic [LW-1:0] acc_req_len = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [LW:0] mem_req_len;
  logic mem_rd_valid = 1'b0, mem_rd_ready;
  logic [DW-1:0] mem_rd_data = '0;
  logic acc_rd_valid, acc_rd_ready = 1'b0;
  logic [DW-1:0] acc_rd_data;
  logic abort;

  tag_load_filter #(.AW(AW), .DW(DW), .IW(IW), .LW(LW), .SW(SW)) dut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  longint cur_s, cur_f, bad_p;
  logic [DW-1:0] cur_tag;
  logic [AW-1:0] cur_base;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_tag(longint p);
    return p >= cur_f && ((p - cur_f) % (cur_s + 1)) == 0;
  endfunction

  function automatic longint phys(longint i);
    longint p = 0, n = 0;
    while (1) begin
      if (!is_tag(p)) begin
        if (n == i) return p;
        n++;
      end
      p++;
    end
  endfunction

  function automatic logic [DW-1:0] word_at(longint p);
    if (is_tag(p)) return (p == bad_p) ? (cur_tag ^ 32'h0000_0100) : cur_tag;
    return 32'hD15C_0000 ^ DW'(p * 40503) ^ cur_tag;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_cfg(longint s, longint f, logic [DW-1:0] t, logic [AW-1:0] b);
    cur_s = s; cur_f = f; cur_tag = t; cur_base = b;
    cfg_stride = SW'(s); cfg_first = IW'(f); cfg_src_tag = t; cfg_base = b;
  endtask

  task automatic run_req(longint idx, longint len, bit exp_abort);
    longint ps, pe, plen, sent, got, exp_got, guard;
    bit busy_ok, saw_mem;
    @(negedge clk);
    acc_req_valid = 1'b1; acc_req_idx = IW'(idx); acc_req_len = LW'(len);
    #1;
    guard = 0;
    while (!acc_req_ready && guard < 200) begin @(negedge clk); #1; guard++; end
    @(negedge clk);
    acc_req_valid = 1'b0;
    if (len == 0) begin
      saw_mem = 1'b0;
      repeat (60) begin @(negedge clk); #1; if (mem_req_valid) saw_mem = 1'b1; end
      check(!saw_mem, "R9", "memory request for zero length", saw_mem, 0);
      check(acc_req_ready, "R9", "ready after zero length", acc_req_ready, 1);
      return;
    end
    ps = phys(idx);
    if (ps > 0 && is_tag(ps - 1)) ps--;
    pe = phys(idx + len - 1);
    if (is_tag(pe + 1)) pe++;
    plen = pe - ps + 1;
    #1;
    guard = 0;
    while (guard < 400) begin
      mem_req_ready = ($urandom % 3) != 0;
      #1;
      if (mem_req_valid && mem_req_ready) break;
      @(negedge clk);
      guard++;
    end
    check(mem_req_addr == cur_base + AW'(ps), "R2", "physical address", mem_req_addr, cur_base + AW'(ps));
    check(longint'(mem_req_len) == plen, "R3", "physical length", mem_req_len, plen);
    sent = 0; got = 0; busy_ok = 1'b1; guard = 0;
    exp_got = 0;
    for (longint p = ps; p <= pe; p++) begin
      if (exp_abort && p >= bad_p) break;
      if (!is_tag(p)) exp_got++;
    end
    while (sent < plen && guard < 5000) begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rd_valid  = ($urandom % 4) != 0;
      mem_rd_data   = word_at(ps + sent);
      acc_rd_ready  = ($urandom % 4) != 0;
      #1;
      if (acc_req_ready) busy_ok = 1'b0;
      if (acc_rd_valid && acc_rd_ready) begin
        check(acc_rd_data == word_at(phys(idx + got)), "R4", "forwarded word",
              acc_rd_data, word_at(phys(idx + got)));
        got++;
      end
      if (mem_rd_valid && mem_rd_ready) sent++;
      guard++;
    end
    @(negedge clk);
    mem_rd_valid = 1'b0; acc_rd_ready = 1'b0;
    #1;
    check(sent == plen, "R6", "beats drained", sent, plen);
    check(got == exp_got, exp_abort ? "R5" : "R4", "words forwarded", got, exp_got);
    check(busy_ok, "R8", "no acceptance during burst", busy_ok, 1);
    check(abort == exp_abort, "R5", "abort flag", abort, exp_abort);
    check(acc_req_ready == !exp_abort, "R7", "ready after burst", acc_req_ready, !exp_abort);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R8 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit leaked;
    void'($urandom(32'd4242));
    bad_p = -1;
    set_cfg(1, 1, 32'hA5A5_0001, 32'h0001_0000);
    do_reset();
    #1;
    check(acc_req_ready == 1'b1, "R1", "reset ready", acc_req_ready, 1);
    check(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", mem_req_valid, 0);
    check(acc_rd_valid == 1'b0, "R1", "reset acc_rd_valid", acc_rd_valid, 0);
    check(abort == 1'b0, "R1", "reset abort", abort, 0);

    run_req(0, 2, 0);                                   // R3: 2 words -> 4 beats
    check(mem_req_len == 4, "R3", "stride-1 burst length", mem_req_len, 4);
    set_cfg(3, 0, 32'h0BAD_F00D, 32'h0002_0000);
    run_req(0, 1, 0);                                   // R2: leading tag at 0
    set_cfg(4, 9, 32'h1234_5678, 32'h0003_0000);
    run_req(2, 5, 0);                                   // R2: burst before first tag
    run_req(5, 7, 0);
    run_req(3, 0, 0);                                   // R9

    for (int n = 0; n < 40; n++) begin
      set_cfg(1 + $urandom % 6, $urandom % 13, $urandom, $urandom & 32'hFFFF_FF00);
      run_req($urandom % 41, 1 + $urandom % 16, 0);
    end

    set_cfg(2, 2, 32'hFEED_0002, 32'h0004_0000);
    bad_p = 5;
    run_req(0, 6, 1);                                   // R5, R6
    @(negedge clk);
    acc_req_valid = 1'b1; acc_req_idx = '0; acc_req_len = LW'(2);
    leaked = 1'b0;
    repeat (20) begin @(negedge clk); #1; if (acc_req_ready || mem_req_valid || !abort) leaked = 1'b1; end
    acc_req_valid = 1'b0;
    check(!leaked, "R7", "blocked after abort", leaked, 0);
    bad_p = -1;
    do_reset();
    #1;
    check(abort == 1'b0 && acc_req_ready, "R1", "reset clears abort", abort, 0);
    run_req(1, 3, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule